// File: doc/BRIEF.md
# Serial Flash Read-Only Slave

This block is the slave end of a serial flash device on an SPI bus (mode 0). It supports only the read and power-management commands: it takes an opcode, a 24-bit address and any dummy bytes on the serial input while chip select is low. It then streams bytes from its storage array out on the serial output, most significant bit first. The serial pins are oversampled by a fast system clock, so all internal logic is synchronous to that clock. The serial output is presented as a data bit plus an output-enable, which a pad or a testbench can turn into a tristate line.

The array covers a 1 MiB byte address space. Only the low `STORE_BITS` address bits select a stored byte, so the storage aliases across the space. The storage is an inferable ROM whose content is computed at elaboration. Two read opcodes are accepted: a plain one, and a fast one that adds a dummy byte. A sleep opcode puts the slave into deep power-down. A wake opcode brings it out of deep power-down and, if clocking continues, returns an identification byte.

Top module: `spi_flash_rd_slave`

## Requirements
- R1: After reset the output-enable is low and the slave is awake, so a read issued right after reset returns data.
- R2: Opcode 03h is followed by three address bytes, sent most significant byte first. Data begins on the SCK falling edge that ends the last address bit, and each byte is sent MSB first. SI is sampled on rising SCK and SO changes on falling SCK.
- R3: Opcode 0Bh behaves like 03h, except that one dummy byte follows the address before data begins.
- R4: The byte stored for address a is (37*i + 90) mod 256, where i = a mod 2^STORE_BITS (STORE_BITS defaults to 8).
- R5: The address advances by one after every byte sent. The address after 0FFFFFh is 000000h, and no extra clocks are needed at the wrap.
- R6: Raising chip select, even in the middle of a byte, drops the output-enable within 4 system clock cycles. The next chip-select low restarts opcode decoding at bit 0.
- R7: Opcode B9h enters deep power-down. While powered down, every opcode other than ABh is ignored and the output-enable stays low.
- R8: Opcode ABh leaves deep power-down. After ABh and three dummy bytes, further clocks return the ID byte (parameter, default 13h), MSB first and repeated. Sending ABh alone is enough to make later reads work.
- R9: An opcode outside {03h, 0Bh, B9h, ABh} keeps the output-enable low for the rest of that chip-select period. The next command is decoded normally.
- R10: With SCK high and low phases of at least 8 system clock cycles each, SO holds its new bit no later than 4 system clock cycles after a falling SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the master |
| spi_so | output | 1 | Serial data to the master |
| spi_so_en | output | 1 | High when spi_so should be driven |

## Verification
A bad bit or byte counter shows up at once as shifted or rotated data bytes: the first data byte read after an address is wrong. A bad address counter shows up on the second byte of a stream, or at the 0FFFFFh wrap. A stuck power-down or ignore state shows up as an output-enable that stays low, or goes high, during the very next chip-select period. An enable left high after chip select rises shows up within four clock cycles.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_FAST  = 8'h0B;
  localparam logic [BYTE_W-1:0] OP_SLEEP = 8'hB9;
  localparam logic [BYTE_W-1:0] OP_WAKE  = 8'hAB;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_WAKE_PAD,
    PH_ID,
    PH_IGNORE
  } phase_t;

  function automatic logic [BYTE_W-1:0] fill_byte(input int idx);
    fill_byte = BYTE_W'((37 * idx + 90) % 256);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_raw,
  input  logic cs_n_raw,
  input  logic si_raw,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic sel_start,
  output logic si_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b010; // {si, cs_n, sck}

  logic [NSIG-1:0]        raw;
  logic [SYNC_STAGES-1:0] pipe [NSIG];
  logic                   sck_q;
  logic                   sel_q;
  logic                   sck_s;

  assign raw = {si_raw, cs_n_raw, sck_raw};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= {SYNC_STAGES{IDLE_VAL[g]}};
      else     pipe[g] <= {pipe[g][SYNC_STAGES-2:0], raw[g]};
    end
  end

  assign sck_s = pipe[0][SYNC_STAGES-1];
  assign sel   = ~pipe[1][SYNC_STAGES-1];
  assign si_s  = pipe[2][SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sel_q <= sel;
    end
  end

  assign sck_rise  = sck_s & ~sck_q;
  assign sck_fall  = ~sck_s & sck_q;
  assign sel_start = sel & ~sel_q;
endmodule

// File: rtl/flash_rom.sv
module flash_rom #(
  parameter int ADDR_W     = 20,
  parameter int STORE_BITS = 8
) (
  input  logic                              clk,
  input  logic [ADDR_W-1:0]                 addr,
  output logic [flash_rd_pkg::BYTE_W-1:0]   rdata
);
  import flash_rd_pkg::*;
  localparam int DEPTH = 1 << STORE_BITS;

  logic [BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = fill_byte(i);
  end

  always_ff @(posedge clk) begin
    rdata <= mem[addr[STORE_BITS-1:0]];
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int                          ADDR_W  = 20,
  parameter logic [flash_rd_pkg::BYTE_W-1:0] ID_BYTE = 8'h13
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            sck_rise,
  input  logic                            sck_fall,
  input  logic                            sel,
  input  logic                            sel_start,
  input  logic                            si_s,
  input  logic [flash_rd_pkg::BYTE_W-1:0] rom_rdata,
  output logic [ADDR_W-1:0]               rom_addr,
  output logic                            so,
  output logic                            so_en,
  output logic                            pwr_down,
  output logic                            ignoring,
  output logic                            byte_load,
  output logic [2:0]                      bit_idx
);
  import flash_rd_pkg::*;
  localparam int ADDR_BYTES = 3;
  localparam int WAKE_PAD   = 3;

  phase_t            phase_q;
  logic [2:0]        bit_q;
  logic [1:0]        cnt_q;
  logic [6:0]        in_sr;
  logic [ADDR_W-1:0] addr_q;
  logic              fast_q;
  logic              pd_q;
  logic [BYTE_W-1:0] out_sr;
  logic              so_q;
  logic              so_en_q;
  logic [BYTE_W-1:0] in_byte;
  logic              out_phase;
  logic [BYTE_W-1:0] next_byte;

  assign in_byte   = {in_sr, si_s};
  assign out_phase = (phase_q == PH_DATA) || (phase_q == PH_ID);
  assign byte_load = sel && sck_fall && out_phase && (bit_q == 3'd0);
  assign next_byte = (phase_q == PH_ID) ? ID_BYTE : rom_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OPCODE;
      bit_q   <= '0;
      cnt_q   <= '0;
      in_sr   <= '0;
      addr_q  <= '0;
      fast_q  <= 1'b0;
      pd_q    <= 1'b0;
      out_sr  <= '0;
      so_q    <= 1'b0;
      so_en_q <= 1'b0;
    end else begin
      if (!sel) so_en_q <= 1'b0;
      if (sel_start) begin
        phase_q <= PH_OPCODE;
        bit_q   <= '0;
        cnt_q   <= '0;
      end else if (sel && sck_rise) begin
        in_sr <= {in_sr[5:0], si_s};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          unique case (phase_q)
            PH_OPCODE: begin
              cnt_q <= '0;
              if (pd_q) begin
                if (in_byte == OP_WAKE) begin
                  pd_q    <= 1'b0;
                  phase_q <= PH_WAKE_PAD;
                end else begin
                  phase_q <= PH_IGNORE;
                end
              end else begin
                unique case (in_byte)
                  OP_READ: begin phase_q <= PH_ADDR; fast_q <= 1'b0; end
                  OP_FAST: begin phase_q <= PH_ADDR; fast_q <= 1'b1; end
                  OP_SLEEP: begin pd_q <= 1'b1; phase_q <= PH_IGNORE; end
                  OP_WAKE: phase_q <= PH_WAKE_PAD;
                  default: phase_q <= PH_IGNORE;
                endcase
              end
            end
            PH_ADDR: begin
              addr_q <= {addr_q[ADDR_W-BYTE_W-1:0], in_byte};
              cnt_q  <= cnt_q + 2'd1;
              if (cnt_q == 2'(ADDR_BYTES - 1))
                phase_q <= fast_q ? PH_DUMMY : PH_DATA;
            end
            PH_DUMMY: phase_q <= PH_DATA;
            PH_WAKE_PAD: begin
              cnt_q <= cnt_q + 2'd1;
              if (cnt_q == 2'(WAKE_PAD - 1)) phase_q <= PH_ID;
            end
            default: ;
          endcase
        end
      end else if (sel && sck_fall && out_phase) begin
        so_en_q <= 1'b1;
        if (bit_q == 3'd0) begin
          so_q   <= next_byte[BYTE_W-1];
          out_sr <= {next_byte[BYTE_W-2:0], 1'b0};
          if (phase_q == PH_DATA) addr_q <= addr_q + 1'b1;
        end else begin
          so_q   <= out_sr[BYTE_W-1];
          out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rom_addr = addr_q;
  assign so       = so_q;
  assign so_en    = so_en_q;
  assign pwr_down = pd_q;
  assign ignoring = (phase_q == PH_IGNORE);
  assign bit_idx  = bit_q;
endmodule

// File: rtl/spi_flash_rd_slave.sv
module spi_flash_rd_slave #(
  parameter int          ADDR_W      = 20,
  parameter int          STORE_BITS  = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  ID_BYTE     = 8'h13
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_si,
  output logic spi_so,
  output logic spi_so_en
);
  import flash_rd_pkg::*;

  logic              sck_rise_w;
  logic              sck_fall_w;
  logic              sel_w;
  logic              sel_start_w;
  logic              si_w;
  logic [BYTE_W-1:0] rom_data_w;
  logic [ADDR_W-1:0] rom_addr_w;
  logic              pd_w;
  logic              ign_w;
  logic              load_w;
  logic [2:0]        bitcnt_w;

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sck_raw(spi_sck), .cs_n_raw(spi_cs_n), .si_raw(spi_si),
    .sck_rise(sck_rise_w), .sck_fall(sck_fall_w),
    .sel(sel_w), .sel_start(sel_start_w), .si_s(si_w)
  );

  flash_rom #(.ADDR_W(ADDR_W), .STORE_BITS(STORE_BITS)) u_rom (
    .clk(clk), .addr(rom_addr_w), .rdata(rom_data_w)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .ID_BYTE(ID_BYTE)) u_fsm (
    .clk(clk), .rst(rst),
    .sck_rise(sck_rise_w), .sck_fall(sck_fall_w),
    .sel(sel_w), .sel_start(sel_start_w), .si_s(si_w),
    .rom_rdata(rom_data_w), .rom_addr(rom_addr_w),
    .so(spi_so), .so_en(spi_so_en),
    .pwr_down(pd_w), .ignoring(ign_w),
    .byte_load(load_w), .bit_idx(bitcnt_w)
  );
endmodule

// File: rtl/flash_rd_checker.sv
module flash_rd_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_cs_n,
  input logic              spi_so,
  input logic              spi_so_en,
  input logic              sck_fall,
  input logic              sel_start,
  input logic              pd,
  input logic              ign,
  input logic              load,
  input logic [2:0]        bitcnt,
  input logic [ADDR_W-1:0] addr
);
  // R10: SO only moves in the cycle after a detected falling SCK edge
  assert_so_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_so) |-> $past(sck_fall));

  // R6: chip select held high for four cycles forces the enable low
  assert_cs_high_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_so_en);

  // R6: a new chip-select period restarts the bit count
  assert_bit_restart_R6: assert property (@(posedge clk) disable iff (rst)
    $past(sel_start) |-> (bitcnt == 3'd0));

  // R7: staying in power-down keeps the output quiet
  assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (pd && $past(pd)) |-> !spi_so_en);

  // R9: ignore state never drives SO
  assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ign |-> !spi_so_en);

  // R5: each byte load advances the address by exactly one, wrapping
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    $past(load) && !$past(ign) && $past(addr) != addr
      |-> addr == ADDR_W'($past(addr) + 1'b1));
endmodule

bind spi_flash_rd_slave flash_rd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n),
  .spi_so(spi_so), .spi_so_en(spi_so_en),
  .sck_fall(sck_fall_w), .sel_start(sel_start_w),
  .pd(pd_w), .ign(ign_w), .load(load_w),
  .bitcnt(bitcnt_w), .addr(rom_addr_w)
);

// File: tb/test_spi_flash_rd_slave.sv
module test_spi_flash_rd_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so;
  logic so_en;

  int compared = 0;
  int mismatched = 0;

  localparam logic [7:0] ID = 8'h13;

  always #10 clk = ~clk;

  spi_flash_rd_slave i_spi_flash_rd_slave (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_si(si), .spi_so(so), .spi_so_en(so_en)
  );

  function automatic logic [7:0] mem_at(input logic [19:0] a);
    mem_at = 8'((37 * int'(a[7:0]) + 90) % 256);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one byte, mode 0; rx sampled 5 clocks after the preceding fall
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic en_all);
    en_all = 1'b1;
    for (int b = 7; b >= 0; b--) begin
      si = tx[b];
      clks(5);
      rx[b] = so;
      en_all = en_all & so_en;
      clks(3);
      sck = 1'b1;
      clks(8);
      sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    clks(8);
  endtask

  task automatic cs_end();
    clks(4);
    cs_n = 1'b1;
    clks(10);
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r;
    logic e;
    xfer(tx, r, e);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [19:0] a, input bit fast);
    send(op);
    send(8'(a >> 16));
    send(a[15:8]);
    send(a[7:0]);
    if (fast) send(8'h00);
  endtask

  task automatic read_run(input string req, input logic [7:0] op, input logic [19:0] a,
                          input bit fast, input int n);
    logic [7:0] r;
    logic e;
    cs_begin();
    send_hdr(op, a, fast);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r, e);
      check({req, " data"}, r, mem_at(20'(a + k)));
      check({req, " enable"}, e, 1'b1);
    end
    cs_end();
  endtask

  task automatic t_reset();
    check("R1 enable after reset", so_en, 1'b0);
    read_run("R1 R4", 8'h03, 20'h00004, 1'b0, 1);
  endtask

  task automatic t_read_plain();
    read_run("R2 R10 R5", 8'h03, 20'h00010, 1'b0, 4);
    read_run("R4 alias", 8'h03, 20'h5A3C7, 1'b0, 2);
  endtask

  task automatic t_read_fast();
    read_run("R3", 8'h0B, 20'h12345, 1'b1, 3);
  endtask

  task automatic t_wrap();
    read_run("R5 wrap", 8'h03, 20'hFFFFE, 1'b0, 4);
    read_run("R5 wrap fast", 8'h0B, 20'hFFFFF, 1'b1, 2);
  endtask

  task automatic t_abort();
    cs_begin();
    send_hdr(8'h03, 20'h00020, 1'b0);
    for (int b = 0; b < 3; b++) begin
      clks(8); sck = 1'b1; clks(8); sck = 1'b0;
    end
    clks(2);
    cs_n = 1'b1;
    clks(4);
    check("R6 enable after cs rise", so_en, 1'b0);
    clks(8);
    read_run("R6 restart", 8'h03, 20'h00021, 1'b0, 1);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    logic e;
    cs_begin();
    send(8'h5A);
    xfer(8'h00, r, e);
    check("R9 quiet 1", e, 1'b0);
    xfer(8'h00, r, e);
    check("R9 quiet 2", e, 1'b0);
    cs_end();
    read_run("R9 next command", 8'h03, 20'h00077, 1'b0, 1);
  endtask

  task automatic sleep();
    cs_begin();
    send(8'hB9);
    cs_end();
  endtask

  task automatic t_sleep();
    logic [7:0] r;
    logic e;
    sleep();
    cs_begin();
    send_hdr(8'h03, 20'h00030, 1'b0);
    xfer(8'h00, r, e);
    check("R7 plain read ignored", e, 1'b0);
    cs_end();
    cs_begin();
    send_hdr(8'h0B, 20'h00030, 1'b1);
    xfer(8'h00, r, e);
    check("R7 fast read ignored", e, 1'b0);
    cs_end();
  endtask

  task automatic t_wake_id();
    logic [7:0] r;
    logic e;
    cs_begin();
    send(8'hAB);
    send(8'h00); send(8'h00); send(8'h00);
    xfer(8'h00, r, e);
    check("R8 id byte", r, ID);
    check("R8 id enable", e, 1'b1);
    xfer(8'h00, r, e);
    check("R8 id repeat", r, ID);
    cs_end();
    read_run("R8 awake after id", 8'h03, 20'h00042, 1'b0, 1);
  endtask

  task automatic t_wake_short();
    sleep();
    cs_begin();
    send(8'hAB);
    cs_end();
    read_run("R8 short wake", 8'h0B, 20'h000C8, 1'b1, 2);
  endtask

  initial begin
    clks(4);
    rst = 1'b0;
    clks(4);
    t_reset();
    t_read_plain();
    t_read_fast();
    t_wrap();
    t_abort();
    t_unknown();
    t_sleep();
    t_wake_id();
    t_wake_short();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule